// File: doc/BRIEF.md
# Serial Controller Register Front End

This block is the register front end of a one-channel serial controller. A CPU reaches it over a byte-wide bus made of a chip select, read and write strobes, a 4-bit offset, and separate write and read data. Several offsets behave differently on read and on write. Offset 0x3 reads status and writes the clock select. Offset 0x7 reads the received byte and writes the byte to transmit. Offset 0x5 is a command port: each write triggers actions and stores nothing. Offset 0x1 reaches two mode registers through a pointer that moves forward on its own.

On the serializer side, the block offers the transmit byte with a valid/ready handshake. It takes in a received byte on a one-cycle valid pulse. It also drives the programmed configuration bytes and the two side-enable levels to the bit-level logic, the baud generator and the interrupt logic around it. A bus access lasts one clock. Read data is combinational while a read is strobed and is 0x00 at all other times.

Top module: `sio_regfront`

## Requirements
- R1: After reset the mode pointer selects mode register 1, both sides are disabled, every configuration output is 0x00, the status byte reads 0x04 and txValid is 0.
- R2: Writing offset 0x3 loads clkSel (upper nibble is the receive rate code, lower nibble the transmit rate code) and leaves the status byte unchanged. Reading offset 0x3 returns status with bit 0 = receiver-ready, bit 2 = transmitter-ready, bit 4 = overrun and all other bits 0.
- R3: The first read or write of offset 0x1 reaches mode register 1 and moves the pointer to mode register 2. Every later access reaches mode register 2 until the pointer is reset.
- R4: A write to offset 0x5 is a one-shot command whose bits 6:4 act as follows: 1 returns the mode pointer to register 1, 2 resets the receiver, 3 resets the transmitter, 4 clears overrun, and 0 does nothing. Consecutive command writes each take effect, and reading offset 0x5 returns 0x00.
- R5: In a command byte, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it; a disable wins over an enable. A disabled receiver ignores rxValid, and a disabled transmitter holds txValid at 0.
- R6: Writing offset 0x7 while transmitter-ready is 1 loads the holding byte and clears transmitter-ready. txValid is 1 exactly when the transmitter is enabled and transmitter-ready is 0. txData stays stable until txValid and txReady are high on the same clock, and that clock sets transmitter-ready again. A write to 0x7 while transmitter-ready is 0 is ignored. A transmitter reset clears the holding byte and sets transmitter-ready.
- R7: An rxValid pulse while the receiver is enabled stores rxData and sets receiver-ready. Reading offset 0x7 returns the stored byte and clears receiver-ready on the next clock. A receiver reset clears receiver-ready and the stored byte.
- R8: A byte that arrives while receiver-ready is 1, with no read of 0x7 on the same clock, sets the overrun bit. The bit stays set until an overrun-clear command.
- R9: Offsets 0x9 and 0xB store the auxiliary control and interrupt mask bytes and read back what was written. Reads of any other offset return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCs | input | 1 | Chip select |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | 4 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, 0x00 when no read is strobed |
| txData | output | 8 | Byte offered to the serializer |
| txValid | output | 1 | Transmit byte valid |
| txReady | input | 1 | Serializer accepts the byte |
| rxData | input | 8 | Byte from the deserializer |
| rxValid | input | 1 | One-cycle pulse marking rxData |
| modeCfg1 | output | 8 | Mode register 1 |
| modeCfg2 | output | 8 | Mode register 2 |
| clkSel | output | 8 | Receive/transmit rate codes |
| auxCtrl | output | 8 | Auxiliary control byte |
| irqMask | output | 8 | Interrupt mask byte |
| rxEnable | output | 1 | Receiver enabled |
| txEnable | output | 1 | Transmitter enabled |

## Verification
A wrong mode pointer appears at the next mode access: the byte lands on the other mode output, or a read returns the other register. A stuck ready flag or a missed command pulse appears in the status byte on the first read after the clock that should have changed it. A stuck flag on the transmit side also shows one clock later as a txValid that is wrongly high or low. A lost or spurious overrun persists until the next overrun-clear command, so any later status read exposes it.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_MODE = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_IRQ  = 4'hB;

  // status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_TXRDY = 2;
  localparam int ST_OVR   = 4;

  typedef enum logic [2:0] {
    MISC_NONE  = 3'd0,
    MISC_PTR   = 3'd1,
    MISC_RXRST = 3'd2,
    MISC_TXRST = 3'd3,
    MISC_ERR   = 3'd4
  } misc_e;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_MODE,
    RSEL_STAT,
    RSEL_DATA,
    RSEL_AUX,
    RSEL_IRQ
  } rsel_e;

  typedef struct packed {
    logic modeAcc;
    logic modeWr;
    logic clkWr;
    logic txWr;
    logic rxRd;
    logic auxWr;
    logic irqWr;
    logic ptrRst;
    logic rxRst;
    logic txRst;
    logic errRst;
    logic rxOn;
    logic rxOff;
    logic txOn;
    logic txOff;
  } strobe_t;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W
) (
  input  logic                busCs,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [ADDR_W_P-1:0] busAddr,
  input  logic [6:0]          cmdBits,
  output strobe_t             stb,
  output rsel_e               rdSel
);
  localparam int NUM_MISC = 5;

  logic wrEn;
  logic rdEn;
  logic cmdWr;
  logic [2:0] miscField;
  logic [NUM_MISC-1:0] miscHit;

  assign wrEn      = busCs & busWr;
  assign rdEn      = busCs & busRd & ~busWr;
  assign cmdWr     = wrEn & (busAddr == OFS_CMD);
  assign miscField = cmdBits[6:4];

  // one-hot decode of the miscellaneous command field
  for (genvar i = 0; i < NUM_MISC; i++) begin : g_misc
    assign miscHit[i] = cmdWr & (miscField == 3'(i));
  end

  always_comb begin
    stb         = '0;
    stb.modeAcc = (wrEn | rdEn) & (busAddr == OFS_MODE);
    stb.modeWr  = wrEn & (busAddr == OFS_MODE);
    stb.clkWr   = wrEn & (busAddr == OFS_STAT);
    stb.txWr    = wrEn & (busAddr == OFS_DATA);
    stb.rxRd    = rdEn & (busAddr == OFS_DATA);
    stb.auxWr   = wrEn & (busAddr == OFS_AUX);
    stb.irqWr   = wrEn & (busAddr == OFS_IRQ);
    stb.ptrRst  = miscHit[MISC_PTR];
    stb.rxRst   = miscHit[MISC_RXRST];
    stb.txRst   = miscHit[MISC_TXRST];
    stb.errRst  = miscHit[MISC_ERR];
    stb.rxOn    = cmdWr & cmdBits[0];
    stb.rxOff   = cmdWr & cmdBits[1];
    stb.txOn    = cmdWr & cmdBits[2];
    stb.txOff   = cmdWr & cmdBits[3];
  end

  always_comb begin
    rdSel = RSEL_NONE;
    if (rdEn) begin
      unique case (busAddr)
        OFS_MODE: rdSel = RSEL_MODE;
        OFS_STAT: rdSel = RSEL_STAT;
        OFS_DATA: rdSel = RSEL_DATA;
        OFS_AUX:  rdSel = RSEL_AUX;
        OFS_IRQ:  rdSel = RSEL_IRQ;
        default:  rdSel = RSEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sio_dpath.sv
module sio_dpath
  import sio_pkg::*;
#(
  parameter int DATA_W_P = DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  rsel_e               rdSel,
  input  logic [DATA_W_P-1:0] busWdata,
  output logic [DATA_W_P-1:0] busRdata,
  output logic [DATA_W_P-1:0] txData,
  output logic                txValid,
  input  logic                txReady,
  input  logic [DATA_W_P-1:0] rxData,
  input  logic                rxValid,
  output logic [DATA_W_P-1:0] modeCfg1,
  output logic [DATA_W_P-1:0] modeCfg2,
  output logic [DATA_W_P-1:0] clkSel,
  output logic [DATA_W_P-1:0] auxCtrl,
  output logic [DATA_W_P-1:0] irqMask,
  output logic                rxEnable,
  output logic                txEnable,
  output logic [DATA_W_P-1:0] statusWord,
  output logic                modePtr
);
  logic [DATA_W_P-1:0] txHold;
  logic [DATA_W_P-1:0] rxHold;
  logic txRdy;
  logic rxRdy;
  logic ovr;
  logic newByte;
  logic txLoad;
  logic txDone;

  assign newByte = rxValid & rxEnable & ~stb.rxRst;
  assign txLoad  = stb.txWr & txRdy;
  assign txValid = txEnable & ~txRdy;
  assign txDone  = txValid & txReady;
  assign txData  = txHold;

  // mode registers behind one offset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCfg1 <= '0;
      modeCfg2 <= '0;
      modePtr  <= 1'b0;
    end else begin
      if (stb.modeWr && !modePtr) modeCfg1 <= busWdata;
      if (stb.modeWr && modePtr)  modeCfg2 <= busWdata;
      if (stb.ptrRst)       modePtr <= 1'b0;
      else if (stb.modeAcc) modePtr <= 1'b1;
    end
  end

  // plain configuration bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSel  <= '0;
      auxCtrl <= '0;
      irqMask <= '0;
    end else begin
      if (stb.clkWr) clkSel  <= busWdata;
      if (stb.auxWr) auxCtrl <= busWdata;
      if (stb.irqWr) irqMask <= busWdata;
    end
  end

  // side enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEnable <= 1'b0;
      txEnable <= 1'b0;
    end else begin
      if (stb.rxOff)     rxEnable <= 1'b0;
      else if (stb.rxOn) rxEnable <= 1'b1;
      if (stb.txOff)     txEnable <= 1'b0;
      else if (stb.txOn) txEnable <= 1'b1;
    end
  end

  // transmit holding
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= '0;
      txRdy  <= 1'b1;
    end else if (stb.txRst) begin
      txHold <= '0;
      txRdy  <= 1'b1;
    end else if (txLoad) begin
      txHold <= busWdata;
      txRdy  <= 1'b0;
    end else if (txDone) begin
      txRdy  <= 1'b1;
    end
  end

  // receive holding and overrun
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold <= '0;
      rxRdy  <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (stb.rxRst) begin
        rxHold <= '0;
        rxRdy  <= 1'b0;
      end else if (newByte) begin
        rxHold <= rxData;
        rxRdy  <= 1'b1;
      end else if (stb.rxRd) begin
        rxRdy  <= 1'b0;
      end
      if (newByte && rxRdy && !stb.rxRd) ovr <= 1'b1;
      else if (stb.errRst)                ovr <= 1'b0;
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[ST_RXRDY] = rxRdy;
    statusWord[ST_TXRDY] = txRdy;
    statusWord[ST_OVR]   = ovr;
  end

  always_comb begin
    unique case (rdSel)
      RSEL_MODE: busRdata = modePtr ? modeCfg2 : modeCfg1;
      RSEL_STAT: busRdata = statusWord;
      RSEL_DATA: busRdata = rxHold;
      RSEL_AUX:  busRdata = auxCtrl;
      RSEL_IRQ:  busRdata = irqMask;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/sio_regfront.sv
module sio_regfront
  import sio_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int ADDR_W_P = ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busCs,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [ADDR_W_P-1:0] busAddr,
  input  logic [DATA_W_P-1:0] busWdata,
  output logic [DATA_W_P-1:0] busRdata,
  output logic [DATA_W_P-1:0] txData,
  output logic                txValid,
  input  logic                txReady,
  input  logic [DATA_W_P-1:0] rxData,
  input  logic                rxValid,
  output logic [DATA_W_P-1:0] modeCfg1,
  output logic [DATA_W_P-1:0] modeCfg2,
  output logic [DATA_W_P-1:0] clkSel,
  output logic [DATA_W_P-1:0] auxCtrl,
  output logic [DATA_W_P-1:0] irqMask,
  output logic                rxEnable,
  output logic                txEnable
);
  strobe_t stb;
  rsel_e   rdSel;
  logic [DATA_W_P-1:0] statusWord;
  logic modePtr;

  sio_ctrl #(.ADDR_W_P(ADDR_W_P)) u_ctrl (
    .busCs   (busCs),
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .cmdBits (busWdata[6:0]),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  sio_dpath #(.DATA_W_P(DATA_W_P)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (rdSel),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .txData     (txData),
    .txValid    (txValid),
    .txReady    (txReady),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .modeCfg1   (modeCfg1),
    .modeCfg2   (modeCfg2),
    .clkSel     (clkSel),
    .auxCtrl    (auxCtrl),
    .irqMask    (irqMask),
    .rxEnable   (rxEnable),
    .txEnable   (txEnable),
    .statusWord (statusWord),
    .modePtr    (modePtr)
  );
endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busCs,
  input logic       busRd,
  input logic       busWr,
  input logic [3:0] busAddr,
  input logic [7:0] busWdata,
  input logic [7:0] txData,
  input logic       txValid,
  input logic       txReady,
  input logic       txEnable,
  input logic       rxValid,
  input logic       rxEnable,
  input logic [7:0] clkSel,
  input logic [7:0] modeCfg1,
  input logic [7:0] statusWord,
  input logic       modePtr
);
  logic cmdWr;
  logic dataRd;
  assign cmdWr  = busCs && busWr && (busAddr == 4'h5);
  assign dataRd = busCs && busRd && !busWr && (busAddr == 4'h7);

  assert_tx_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> txEnable);

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !cmdWr) |=> (txValid && $stable(txData)));

  assert_rx_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxEnable && !cmdWr) |=> statusWord[0]);

  assert_rx_drain_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !rxValid) |=> !statusWord[0]);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[4] && !(cmdWr && busWdata[6:4] == 3'd4)) |=> statusWord[4]);

  assert_clksel_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busCs && busWr && busAddr == 4'h3) |=> (clkSel == $past(busWdata)));

  assert_mode_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busCs && busWr && busAddr == 4'h1 && !modePtr) |=>
      (modeCfg1 == $past(busWdata) && modePtr));
endmodule

bind sio_regfront sio_regfront_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busCs      (busCs),
  .busRd      (busRd),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .txData     (txData),
  .txValid    (txValid),
  .txReady    (txReady),
  .txEnable   (txEnable),
  .rxValid    (rxValid),
  .rxEnable   (rxEnable),
  .clkSel     (clkSel),
  .modeCfg1   (modeCfg1),
  .statusWord (statusWord),
  .modePtr    (modePtr)
);

// File: tb/sim_sio_regfront.sv
`timescale 1ns/1ps
module sim_sio_regfront;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCs = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] txData;
  logic txValid;
  logic txReady = 1'b0;
  logic [7:0] rxData = '0;
  logic rxValid = 1'b0;
  logic [7:0] modeCfg1, modeCfg2, clkSel, auxCtrl, irqMask;
  logic rxEnable, txEnable;

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  sio_regfront u0 (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .modeCfg1(modeCfg1),
    .modeCfg2(modeCfg2), .clkSel(clkSel), .auxCtrl(auxCtrl),
    .irqMask(irqMask), .rxEnable(rxEnable), .txEnable(txEnable)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares every strobed read against the scoreboard
  always @(negedge clk) begin
    if (busCs && busRd) begin
      if (expQ.size() == 0) chk(busRdata, 8'hxx, "unexpected read");
      else chk(busRdata, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busCs = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busCs = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    busCs = 1; busRd = 1; busAddr = a;
    @(posedge clk); #1;
    busCs = 0; busRd = 0;
  endtask

  task automatic rxPush(input logic [7:0] d);
    @(posedge clk); #1;
    rxValid = 1; rxData = d;
    @(posedge clk); #1;
    rxValid = 0;
  endtask

  task automatic txAccept();
    @(posedge clk); #1;
    txReady = 1;
    @(posedge clk); #1;
    txReady = 0;
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk(modeCfg1, 8'h00, "R1 modeCfg1");
    chk(modeCfg2, 8'h00, "R1 modeCfg2");
    chk(clkSel, 8'h00, "R1 clkSel");
    chk({6'b0, rxEnable, txEnable}, 8'h00, "R1 enables");
    chk({7'b0, txValid}, 8'h00, "R1 txValid");
    chk(busRdata, 8'h00, "R9 idle read data");
    busRead(4'h3, 8'h04, "R1 status after reset");

    // R2 clock select shares offset with status
    busWrite(4'h3, 8'hCC);
    chk(clkSel, 8'hCC, "R2 clkSel");
    busRead(4'h3, 8'h04, "R2 status unchanged");

    // R3 mode pointer
    busWrite(4'h1, 8'h13);
    busWrite(4'h1, 8'h0F);
    chk(modeCfg1, 8'h13, "R3 first write to mode1");
    chk(modeCfg2, 8'h0F, "R3 second write to mode2");
    busWrite(4'h1, 8'h55);
    chk(modeCfg1, 8'h13, "R3 mode1 kept");
    chk(modeCfg2, 8'h55, "R3 later write to mode2");
    busRead(4'h1, 8'h55, "R3 read reaches mode2");
    busWrite(4'h5, 8'h10);
    busRead(4'h1, 8'h13, "R4 pointer reset then mode1");
    busRead(4'h1, 8'h55, "R3 read advanced pointer");

    // R9 aux/irq and unmapped
    busWrite(4'h9, 8'hF0);
    busWrite(4'hB, 8'hA5);
    busRead(4'h9, 8'hF0, "R9 aux readback");
    busRead(4'hB, 8'hA5, "R9 irq readback");
    busRead(4'h0, 8'h00, "R9 unmapped 0x0");
    busRead(4'hF, 8'h00, "R9 unmapped 0xF");
    busRead(4'h5, 8'h00, "R4 command port reads zero");
    chk(auxCtrl, 8'hF0, "R9 auxCtrl");
    chk(irqMask, 8'hA5, "R9 irqMask");

    // R5 disabled sides
    rxPush(8'h41);
    busRead(4'h3, 8'h04, "R5 disabled rx ignores byte");
    busRead(4'h7, 8'h00, "R5 no byte stored");
    busWrite(4'h7, 8'h99);
    chk({7'b0, txValid}, 8'h00, "R5 disabled tx not offered");
    busRead(4'h3, 8'h00, "R6 tx holding full");
    busWrite(4'h5, 8'h30);
    busRead(4'h3, 8'h04, "R6 tx reset sets ready");
    busWrite(4'h5, 8'h05);
    chk({6'b0, rxEnable, txEnable}, 8'h03, "R5 enable both");
    chk({7'b0, txValid}, 8'h00, "R6 reset discarded held byte");

    // R6 transmit handshake
    busWrite(4'h7, 8'h5A);
    chk({7'b0, txValid}, 8'h01, "R6 txValid after load");
    chk(txData, 8'h5A, "R6 txData");
    busWrite(4'h7, 8'h77);
    chk(txData, 8'h5A, "R6 write while busy ignored");
    txAccept();
    chk({7'b0, txValid}, 8'h00, "R6 txValid drops after accept");
    busRead(4'h3, 8'h04, "R6 ready after accept");

    // R7 receive path
    rxPush(8'h41);
    busRead(4'h3, 8'h05, "R7 receiver ready");
    busRead(4'h7, 8'h41, "R7 received byte");
    busRead(4'h3, 8'h04, "R7 ready cleared by read");

    // R8 overrun
    rxPush(8'h11);
    rxPush(8'h22);
    busRead(4'h3, 8'h15, "R8 overrun set");
    busRead(4'h7, 8'h22, "R8 newest byte kept");
    busRead(4'h3, 8'h14, "R8 overrun sticky after read");
    busWrite(4'h5, 8'h40);
    busRead(4'h3, 8'h04, "R8 overrun cleared");

    // R7 receiver reset, back-to-back commands
    rxPush(8'h33);
    busWrite(4'h5, 8'h20);
    busWrite(4'h5, 8'h10);
    busRead(4'h3, 8'h04, "R7 rx reset clears ready");
    busRead(4'h7, 8'h00, "R7 rx reset clears byte");
    busRead(4'h1, 8'h13, "R4 second command also applied");

    // R5 disable bits
    busWrite(4'h5, 8'h0A);
    chk({6'b0, rxEnable, txEnable}, 8'h00, "R5 disable both");

    repeat (2) @(posedge clk);
    chk(8'(expQ.size()), 8'h00, "scoreboard drained");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule